// File: doc/BRIEF.md
# Five-Level Third-Order Noise Shaper

This block converts oversampled 24-bit signed audio samples into a stream of five-level codes for a multi-level DAC element. Samples are offered on a valid/ready input at eight times the audio rate. Internally a clock divider produces an update strobe. On each strobe, three cascaded integrators with quantizer feedback run one step, and the quantizer emits one code from 0 to 4. Between updates, the most recently accepted sample is held unchanged (zero-order hold).

A ratio select picks the update rate. With the 384x system-clock ratio the loop steps once every 8 clocks, which gives 6 steps per input sample. With the 256x ratio it steps once every 4 clocks, which gives 8 steps per input sample. A mute input forces the midscale code and empties the loop. The input side applies back-pressure: after a sample is taken, `in_ready` stays low until the loop has stepped at least once on it. The output has no back-pressure, because the DAC element consumes one code per strobe and cannot stall. `out_valid` marks the cycle that follows each update.

Top module: `dsm_noise_shaper`

## Requirements
- R1: While `rst` is high at a clock edge, `out_code` becomes 2, `out_valid` becomes 0, `in_ready` becomes 1, all three integrators become zero, the held sample becomes zero and the divider count becomes zero.
- R2: Strobes occur every 4 clocks when `ratio_sel`=0 and every 8 clocks when `ratio_sel`=1. The first strobe falls on the 4th or 8th edge after reset is released. `out_valid` is high for exactly the one cycle after each strobe edge.
- R3: A sample is taken on an edge where `in_valid` and `in_ready` are both high. It is held, as two's complement sign-extended to the integrator width, until the next accepted sample. A strobe at the same edge as an accept still uses the previous sample.
- R4: After an accept, `in_ready` is 0 until the next strobe edge that has no accept at the same edge.
- R5: On each unmuted strobe, with states s0, s1, s2 and feedback level v: s0 ← sat(s0 + x − v), s1 ← sat(s1 + (s0 >>> 1) − v), s2 ← sat(s2 + (s1 >>> 2) − v). All right-hand values are taken from before the strobe.
- R6: At a strobe, with FS = 2^23, the code is quantized from s2 as follows: 0 if s2 < −3FS/4; 1 if s2 < −FS/4; 2 if s2 < FS/4; 3 if s2 < 3FS/4; otherwise 4. This code appears on `out_code` after the strobe edge.
- R7: The feedback level for codes 0 to 4 is −FS, −FS/2, 0, +FS/2, +FS respectively.
- R8: Integrators are 28-bit signed and clamp at −2^27 and 2^27−1 instead of wrapping.
- R9: When `mute` is high at a strobe edge, `out_code` becomes 2 and all integrators become zero.
- R10: `out_code` changes only at strobe edges. In any cycle where `out_valid` is 0, it equals its value from the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ratio_sel | input | 1 | 0: 256x ratio (strobe every 4 clocks), 1: 384x ratio (strobe every 8) |
| mute | input | 1 | Force midscale code and clear the loop at strobes |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can take a sample |
| in_data | input | 24 | Two's complement input sample |
| out_valid | output | 1 | High in the cycle after an update |
| out_code | output | 3 | Five-level code, 0 to 4 |

## Verification
The assertions assume that `ratio_sel` changes only while `rst` is high, so the divider never sees its limit move under a running count. They also assume that the divider limits are at least 2, so two strobes can never be adjacent. The stimulus sets the ratio before each reset and leaves it unchanged for the whole run that follows. Mute windows begin and end at arbitrary clocks, and `in_valid` is dropped on some cycles; neither of these is restricted by any assumption.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
  typedef logic [2:0] lvl_code_t;
  localparam lvl_code_t MID_CODE = 3'd2;
  typedef enum logic {RATIO_256 = 1'b0, RATIO_384 = 1'b1} clk_ratio_e;
endpackage

// File: rtl/dsm_tick_gen.sv
module dsm_tick_gen
  import dsm_pkg::*;
#(
  parameter int DIV_256 = 4,
  parameter int DIV_384 = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic ratio_sel,
  output logic tick
);
  localparam int DIV_MAX = (DIV_384 > DIV_256) ? DIV_384 : DIV_256;
  localparam int CNT_W   = $clog2(DIV_MAX + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  assign lim  = (ratio_sel == RATIO_384) ? CNT_W'(DIV_384 - 1) : CNT_W'(DIV_256 - 1);
  assign tick = (cnt_q == lim);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst) tick |=> !tick);
endmodule

// File: rtl/dsm_integ.sv
module dsm_integ #(
  parameter int ACC_W = 28,
  parameter int SHIFT = 0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    clr,
  input  logic signed [ACC_W-1:0] in_val,
  input  logic signed [ACC_W-1:0] fb,
  output logic signed [ACC_W-1:0] state
);
  localparam int     EXT_W = ACC_W + 2;
  localparam longint MAX_L = (64'sd1 <<< (ACC_W - 1)) - 64'sd1;
  localparam longint MIN_L = -(64'sd1 <<< (ACC_W - 1));
  localparam logic signed [EXT_W-1:0] MAX_V = EXT_W'(MAX_L);
  localparam logic signed [EXT_W-1:0] MIN_V = EXT_W'(MIN_L);

  logic signed [ACC_W-1:0] state_q;
  logic signed [ACC_W-1:0] scaled;
  logic signed [EXT_W-1:0] sum;
  logic signed [ACC_W-1:0] nxt;

  assign scaled = in_val >>> SHIFT;
  assign sum = {{2{state_q[ACC_W-1]}}, state_q}
             + {{2{scaled[ACC_W-1]}}, scaled}
             - {{2{fb[ACC_W-1]}}, fb};

  always_comb begin
    if (sum > MAX_V)      nxt = MAX_V[ACC_W-1:0];
    else if (sum < MIN_V) nxt = MIN_V[ACC_W-1:0];
    else                  nxt = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)      state_q <= '0;
    else if (en)  state_q <= clr ? '0 : nxt;
  end

  assign state = state_q;

  // R9
  integ_clr_chk: assert property (@(posedge clk) disable iff (rst) (en && clr) |=> (state == '0));
endmodule

// File: rtl/dsm_quant.sv
module dsm_quant
  import dsm_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int ACC_W  = 28
) (
  input  logic signed [ACC_W-1:0] value,
  output lvl_code_t               code,
  output logic signed [ACC_W-1:0] level
);
  localparam longint FS_L = 64'sd1 <<< (DATA_W - 1);
  localparam logic signed [ACC_W-1:0] FSV = ACC_W'(FS_L);
  localparam logic signed [ACC_W-1:0] HFS = ACC_W'(FS_L / 2);
  localparam logic signed [ACC_W-1:0] T1  = ACC_W'(FS_L / 4);
  localparam logic signed [ACC_W-1:0] T3  = ACC_W'((3 * FS_L) / 4);

  always_comb begin
    if (value < -T3)      code = 3'd0;
    else if (value < -T1) code = 3'd1;
    else if (value < T1)  code = 3'd2;
    else if (value < T3)  code = 3'd3;
    else                  code = 3'd4;
  end

  always_comb begin
    case (code)
      3'd0:    level = -FSV;
      3'd1:    level = -HFS;
      3'd3:    level = HFS;
      3'd4:    level = FSV;
      default: level = '0;
    endcase
  end
endmodule

// File: rtl/dsm_noise_shaper.sv
module dsm_noise_shaper
  import dsm_pkg::*;
#(
  parameter int DATA_W  = 24,
  parameter int ACC_W   = 28,
  parameter int ORDER   = 3,
  parameter int DIV_256 = 4,
  parameter int DIV_384 = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ratio_sel,
  input  logic              mute,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [2:0]        out_code
);
  localparam int EXT_BITS = ACC_W - DATA_W;

  logic                    tick;
  logic [DATA_W-1:0]       hold_q;
  logic                    slot_free_q;
  logic signed [ACC_W-1:0] x_ext;
  logic signed [ACC_W-1:0] st     [ORDER];
  logic signed [ACC_W-1:0] stg_in [ORDER];
  lvl_code_t               q_code;
  logic signed [ACC_W-1:0] q_level;
  lvl_code_t               code_q;
  logic                    valid_q;

  dsm_tick_gen #(.DIV_256(DIV_256), .DIV_384(DIV_384)) u_tick (
    .clk(clk), .rst(rst), .ratio_sel(ratio_sel), .tick(tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q      <= '0;
      slot_free_q <= 1'b1;
    end else if (in_valid && slot_free_q) begin
      hold_q      <= in_data;
      slot_free_q <= 1'b0;
    end else if (tick) begin
      slot_free_q <= 1'b1;
    end
  end

  assign in_ready = slot_free_q;
  assign x_ext    = {{EXT_BITS{hold_q[DATA_W-1]}}, hold_q};

  for (genvar k = 0; k < ORDER; k++) begin : g_stage
    if (k == 0) begin : g_head
      assign stg_in[k] = x_ext;
    end else begin : g_chain
      assign stg_in[k] = st[k-1];
    end
    dsm_integ #(.ACC_W(ACC_W), .SHIFT(k)) u_integ (
      .clk(clk), .rst(rst), .en(tick), .clr(mute),
      .in_val(stg_in[k]), .fb(q_level), .state(st[k])
    );
  end

  dsm_quant #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_quant (
    .value(st[ORDER-1]), .code(q_code), .level(q_level)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q  <= MID_CODE;
      valid_q <= 1'b0;
    end else begin
      valid_q <= tick;
      if (tick) code_q <= mute ? MID_CODE : q_code;
    end
  end

  assign out_code  = code_q;
  assign out_valid = valid_q;

  // R4
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst) (in_valid && in_ready) |=> !in_ready);
  // R10
  code_hold_chk: assert property (@(posedge clk) disable iff (rst) !out_valid |-> $stable(out_code));
  // R9
  mute_mid_chk: assert property (@(posedge clk) disable iff (rst) (tick && mute) |=> (out_code == MID_CODE));
endmodule

// File: tb/dsm_noise_shaper_tb.sv
module dsm_noise_shaper_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam longint FS     = 64'sd1 <<< 23;
  localparam longint SMAX   = (64'sd1 <<< 27) - 1;
  localparam longint SMIN   = -(64'sd1 <<< 27);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ratio_sel = 1'b0;
  logic mute = 1'b0;
  logic in_valid = 1'b0;
  logic [23:0] in_data = '0;
  logic in_ready, out_valid;
  logic [2:0] out_code;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsm_noise_shaper dut_i (
    .clk(clk), .rst(rst), .ratio_sel(ratio_sel), .mute(mute),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_code(out_code)
  );

  function automatic longint sat(longint v);
    if (v > SMAX) return SMAX;
    if (v < SMIN) return SMIN;
    return v;
  endfunction

  function automatic int quant(longint v);
    if (v < -(3*FS)/4) return 0;
    if (v < -FS/4)     return 1;
    if (v < FS/4)      return 2;
    if (v < (3*FS)/4)  return 3;
    return 4;
  endfunction

  function automatic longint lvl(int c);
    case (c)
      0: return -FS;
      1: return -FS/2;
      3: return FS/2;
      4: return FS;
      default: return 0;
    endcase
  endfunction

  // reference model, updated at the clock edge from inputs driven at negedges
  int m_cnt;
  longint m_s0, m_s1, m_s2, m_hold;
  int m_code;
  bit m_valid, m_rdy, m_mute_tick;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_s0 = 0; m_s1 = 0; m_s2 = 0; m_hold = 0;
      m_code = 2; m_valid = 0; m_rdy = 1; m_mute_tick = 0;
    end else begin
      int lim;
      bit tk, acc;
      lim = ratio_sel ? 8 : 4;
      tk  = (m_cnt == lim - 1);
      m_cnt = tk ? 0 : m_cnt + 1;
      acc = in_valid && m_rdy;
      m_valid = tk;
      if (tk) begin
        int q;
        longint v, n0, n1, n2;
        q = quant(m_s2);
        v = lvl(q);
        m_mute_tick = mute;
        m_code = mute ? 2 : q;
        if (mute) begin
          m_s0 = 0; m_s1 = 0; m_s2 = 0;
        end else begin
          n0 = sat(m_s0 + m_hold - v);
          n1 = sat(m_s1 + (m_s0 >>> 1) - v);
          n2 = sat(m_s2 + (m_s1 >>> 2) - v);
          m_s0 = n0; m_s1 = n1; m_s2 = n2;
        end
      end
      if (acc) begin
        m_hold = longint'($signed(in_data));
        m_rdy = 0;
      end else if (tk) begin
        m_rdy = 1;
      end
    end
  end

  task automatic check(bit ok, string req, longint act, longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // output monitor at the falling edge
  int cyc = 0;
  int last_tick = -1;
  int prev_code = 2;
  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      last_tick = -1;
      prev_code = 2;
    end else if (!done) begin
      check(out_valid == m_valid, "R2 valid", out_valid, m_valid);
      check(in_ready == m_rdy, "R3 R4 ready", in_ready, m_rdy);
      check(int'(out_code) == m_code, "R5 R6 R7 R8 code", out_code, m_code);
      if (out_valid) begin
        if (last_tick >= 0)
          check(cyc - last_tick == (ratio_sel ? 8 : 4), "R2 interval", cyc - last_tick, ratio_sel ? 8 : 4);
        last_tick = cyc;
        if (m_mute_tick) check(out_code == 3'd2, "R9 mute", out_code, 2);
      end else begin
        check(int'(out_code) == prev_code, "R10 hold", out_code, prev_code);
      end
      prev_code = int'(out_code);
    end
  end

  function automatic logic [23:0] pattern(int p, int i);
    case (p)
      0: return 24'h000000;
      1: return 24'h7FFFFF;
      2: return 24'h800000;
      3: return 24'h200000;
      4: return 24'(-32'sd3145728);
      5: return 24'(i * 4099);
      6: return ((i / 16) % 2 == 0) ? 24'h7FFFFF : 24'h800001;
      default: return 24'(12345 * ((i % 5) - 2));
    endcase
  endfunction

  initial begin
    for (int r = 0; r < 2; r++) begin
      @(negedge clk);
      rst = 1'b1;
      ratio_sel = r[0];
      mute = 1'b0;
      in_valid = 1'b0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(out_code == 3'd2, "R1 code", out_code, 2);
      check(out_valid == 1'b0, "R1 valid", out_valid, 0);
      check(in_ready == 1'b1, "R1 ready", in_ready, 1);
      rst = 1'b0;
      for (int p = 0; p < 8; p++) begin
        for (int i = 0; i < 300; i++) begin
          in_valid = (i % 3 != 2);
          in_data  = pattern(p, i);
          mute     = (p == 3 && i >= 100 && i < 170) || (p == 6 && i >= 250);
          @(negedge clk);
        end
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule